// File: doc/BRIEF.md
# Broadcast Data Group Status and Interrupt Logic

This block sits behind a radio data block decoder and turns the decoder's per-group results into host-visible status and an interrupt line. For each decoded group the decoder raises a one-cycle strobe, together with a flag that says whether the group was valid, a level that says whether the decoder is currently synchronized, and a raw bit-error count for each of the four blocks of the group. The block turns these into a ready flag with a guaranteed minimum hold time, a synchronization status flag, four two-bit error levels and an active-low interrupt pin.

Two operating modes are offered. In standard mode only valid groups count, and the synchronization flag and error levels read as zero. In verbose mode any group received while synchronized counts, the synchronization flag follows the decoder, and the error levels are live. The interrupt pin pulses low for its own minimum time when interrupts are enabled and the pin's function code selects the interrupt role. Both minimum times are counted in clock ticks derived from a clock-frequency parameter.

Top module: `rds_grp_status`

## Requirements
- R1: While `rds_on` is low the block is inactive: from the first clock edge at which it is sampled low, `ready_flag` and `sync_flag` are 0, `err_level` is 0, `gpio2_n` is 1, and strobes are ignored.
- R2: In standard mode a strobe with `grp_ok` = 1 sets `ready_flag` after the next clock edge; a strobe with `grp_ok` = 0 neither sets `ready_flag` nor drives `gpio2_n` low.
- R3: In standard mode `sync_flag` and all four error levels read 0, even after strobes with non-zero error counts.
- R4: In verbose mode `sync_flag` follows `grp_locked` one clock edge later, going high when it rises and low when it falls.
- R5: In verbose mode a strobe sets `ready_flag` when `grp_locked` is 1, whatever `grp_ok` is, and does not set it when `grp_locked` is 0.
- R6: After a qualifying group `ready_flag` stays high for exactly READY_MS x CLK_HZ/1000 clock cycles; a new qualifying group during that time restarts the full count.
- R7: When `irq_on` = 1 and `pin2_func` = 2'b01, each qualifying group drives `gpio2_n` low for exactly PULSE_MS x CLK_HZ/1000 cycles, restarting on a new qualifying group; the pin is low only while `ready_flag` is high.
- R8: `gpio2_n` is 1 whenever `irq_on` = 0 or `pin2_func` differs from 2'b01.
- R9: Each block's error count maps to a level of 2'b00 for zero errors, 2'b01 for one or two, 2'b10 for three to five and 2'b11 (uncorrectable) for six or more; block A occupies `err_level[1:0]`, B `[3:2]`, C `[5:4]`, D `[7:6]`, and `blk_err_cnt` packs block A in its lowest ERR_CNT_W bits in the same order. Levels are captured on each strobe and held until the next.
- R10: `verbose_sel` (1 = verbose) is registered and takes effect one clock edge after it is sampled; synchronous reset `rst` clears every flag and timer, releases `gpio2_n` high and selects standard mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rds_on | input | 1 | Enables the whole function |
| verbose_sel | input | 1 | Mode select: 0 standard, 1 verbose |
| irq_on | input | 1 | Interrupt enable |
| pin2_func | input | 2 | Pin function code; 2'b01 selects interrupt |
| grp_stb | input | 1 | One-cycle strobe per decoded group |
| grp_ok | input | 1 | Group passed validity checks |
| grp_locked | input | 1 | Decoder is block-synchronized |
| blk_err_cnt | input | 4*ERR_CNT_W | Raw bit-error counts, block A lowest |
| ready_flag | output | 1 | Group ready, held for minimum time |
| sync_flag | output | 1 | Synchronization status (verbose only) |
| err_level | output | 8 | Four two-bit error levels, A lowest |
| gpio2_n | output | 1 | Active-low interrupt pin |

## Verification
Groups are sent in both modes with the validity and synchronization flags crossed, so that standard mode is shown to key on validity alone and verbose mode on synchronization alone. Error counts chosen at every boundary of the level code (0, 1, 2, 3, 5, 6, 15) tell apart off-by-one range edges and swapped field positions, and changing counts without a strobe shows the levels are held. Hold and pulse lengths are measured at their last high and first low cycle, with and without a second group mid-hold, which separates a restarting timer from a free-running one. The pin is tried with every gating combination, and disable and reset are applied mid-hold.

// File: rtl/rds_grp_pkg.sv
package rds_grp_pkg;

   typedef enum logic {
      MODE_STD  = 1'b0,
      MODE_VERB = 1'b1
   } grp_mode_e;

   localparam logic [1:0] PIN_FUNC_IRQ = 2'b01;

   localparam int unsigned NUM_BLOCKS = 4;
   localparam int unsigned LVL_W      = 2;

   typedef logic [LVL_W-1:0] err_lvl_t;

   localparam err_lvl_t LVL_CLEAN = 2'b00;
   localparam err_lvl_t LVL_LOW   = 2'b01;
   localparam err_lvl_t LVL_MID   = 2'b10;
   localparam err_lvl_t LVL_BAD   = 2'b11;

   function automatic err_lvl_t grade_errors(input int unsigned n);
      err_lvl_t r;
      if (n == 0)      r = LVL_CLEAN;
      else if (n <= 2) r = LVL_LOW;
      else if (n <= 5) r = LVL_MID;
      else             r = LVL_BAD;
      return r;
   endfunction

endpackage

// File: rtl/rds_err_grade.sv
module rds_err_grade
   import rds_grp_pkg::*;
#(
   parameter int unsigned CNT_W = 4
) (
   input  logic [CNT_W-1:0] cnt,
   output err_lvl_t         lvl
);

   if (CNT_W < 3) begin : g_bad_width
      $error("rds_err_grade: CNT_W must reach a count of six");
   end

   always_comb begin
      lvl = grade_errors(32'(cnt));
   end

endmodule

// File: rtl/rds_hold_timer.sv
module rds_hold_timer #(
   parameter int unsigned TICKS = 1000
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic load,
   output logic busy
);

   localparam int unsigned CW = $clog2(TICKS + 1);

   if (TICKS < 2) begin : g_bad_ticks
      $error("rds_hold_timer: TICKS must be at least 2");
   end

   logic [CW-1:0] remain;

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         remain <= '0;
      end else if (load) begin
         remain <= CW'(TICKS);
      end else if (remain != '0) begin
         remain <= remain - CW'(1);
      end
   end

   assign busy = (remain != '0);

   // R6 / R7: a load always yields an active hold on the next cycle
   assert_load_starts_R6: assert property (@(posedge clk) disable iff (rst)
      (load && !clr) |=> busy);

   // R6 / R7: the hold never ends before its last tick
   assert_no_early_drop_R6: assert property (@(posedge clk) disable iff (rst)
      (busy && !clr && !load && remain > CW'(1)) |=> busy);

   // R6 / R7: the hold ends right after its last tick
   assert_ends_on_time_R7: assert property (@(posedge clk) disable iff (rst)
      (remain == CW'(1) && !load) |=> !busy);

endmodule

// File: rtl/rds_grp_status.sv
module rds_grp_status
   import rds_grp_pkg::*;
#(
   parameter int unsigned CLK_HZ    = 50_000_000,
   parameter int unsigned READY_MS  = 40,
   parameter int unsigned PULSE_MS  = 5,
   parameter int unsigned ERR_CNT_W = 4
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             rds_on,
   input  logic                             verbose_sel,
   input  logic                             irq_on,
   input  logic [1:0]                       pin2_func,
   input  logic                             grp_stb,
   input  logic                             grp_ok,
   input  logic                             grp_locked,
   input  logic [NUM_BLOCKS*ERR_CNT_W-1:0]  blk_err_cnt,
   output logic                             ready_flag,
   output logic                             sync_flag,
   output logic [NUM_BLOCKS*LVL_W-1:0]      err_level,
   output logic                             gpio2_n
);

   localparam int unsigned TICKS_PER_MS = CLK_HZ / 1000;
   localparam int unsigned READY_TICKS  = READY_MS * TICKS_PER_MS;
   localparam int unsigned PULSE_TICKS  = PULSE_MS * TICKS_PER_MS;
   localparam int unsigned LVL_BUS_W    = NUM_BLOCKS * LVL_W;

   if (CLK_HZ < 1000) begin : g_bad_clk
      $error("rds_grp_status: CLK_HZ must be at least 1 kHz");
   end
   if (PULSE_MS == 0 || PULSE_MS > READY_MS) begin : g_bad_pulse
      $error("rds_grp_status: pulse time must be non-zero and within ready hold");
   end

   // mode register
   grp_mode_e mode_q;

   always_ff @(posedge clk) begin
      if (rst) mode_q <= MODE_STD;
      else     mode_q <= verbose_sel ? MODE_VERB : MODE_STD;
   end

   // group qualification
   logic counts_group;
   logic pin_is_irq;
   logic pulse_load;

   always_comb begin
      counts_group = 1'b0;
      if (rds_on && grp_stb) begin
         counts_group = (mode_q == MODE_VERB) ? grp_locked : grp_ok;
      end
   end

   assign pin_is_irq = irq_on && (pin2_func == PIN_FUNC_IRQ);
   assign pulse_load = counts_group && pin_is_irq;

   // hold timers
   logic ready_busy;
   logic pulse_busy;

   rds_hold_timer #(.TICKS(READY_TICKS)) u_ready_hold (
      .clk  (clk),
      .rst  (rst),
      .clr  (!rds_on),
      .load (counts_group),
      .busy (ready_busy)
   );

   rds_hold_timer #(.TICKS(PULSE_TICKS)) u_pulse_hold (
      .clk  (clk),
      .rst  (rst),
      .clr  (!rds_on),
      .load (pulse_load),
      .busy (pulse_busy)
   );

   assign ready_flag = ready_busy;
   assign gpio2_n    = !(pulse_busy && pin_is_irq);

   // synchronization status
   logic sync_q;

   always_ff @(posedge clk) begin
      if (rst || !rds_on)           sync_q <= 1'b0;
      else if (mode_q == MODE_VERB) sync_q <= grp_locked;
      else                          sync_q <= 1'b0;
   end

   assign sync_flag = sync_q;

   // error level grading and capture
   logic [LVL_BUS_W-1:0] lvl_now;
   logic [LVL_BUS_W-1:0] lvl_held;

   for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
      rds_err_grade #(.CNT_W(ERR_CNT_W)) u_grade (
         .cnt (blk_err_cnt[b*ERR_CNT_W +: ERR_CNT_W]),
         .lvl (lvl_now[b*LVL_W +: LVL_W])
      );
   end

   always_ff @(posedge clk) begin
      if (rst || !rds_on) lvl_held <= '0;
      else if (grp_stb)   lvl_held <= lvl_now;
   end

   assign err_level = (mode_q == MODE_VERB) ? lvl_held : '0;

   // checks
   assert_disable_quiet_R1: assert property (@(posedge clk) disable iff (rst)
      !rds_on |=> (!ready_flag && !sync_flag && gpio2_n));

   assert_valid_sets_ready_R2: assert property (@(posedge clk) disable iff (rst)
      (rds_on && mode_q == MODE_STD && grp_stb && grp_ok) |=> ready_flag);

   assert_invalid_ignored_R2: assert property (@(posedge clk) disable iff (rst)
      (rds_on && mode_q == MODE_STD && grp_stb && !grp_ok && !ready_flag)
         |=> (!ready_flag && gpio2_n));

   assert_std_no_sync_R3: assert property (@(posedge clk) disable iff (rst)
      (mode_q == MODE_STD && $past(mode_q) == MODE_STD) |-> !sync_flag);

   assert_sync_tracks_R4: assert property (@(posedge clk) disable iff (rst)
      (rds_on && mode_q == MODE_VERB) |=> (sync_flag == $past(grp_locked)));

   assert_verbose_ready_R5: assert property (@(posedge clk) disable iff (rst)
      (rds_on && mode_q == MODE_VERB && grp_stb && grp_locked) |=> ready_flag);

   assert_pin_within_ready_R7: assert property (@(posedge clk) disable iff (rst)
      !gpio2_n |-> ready_flag);

   assert_levels_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (rds_on && !grp_stb && $past(rds_on)) |=> $stable(lvl_held));

endmodule

// File: tb/rds_grp_status_bench.sv
module rds_grp_status_bench;

   localparam int unsigned CLK_HZ   = 100_000;
   localparam int unsigned READY_T  = 40 * (CLK_HZ / 1000);
   localparam int unsigned PULSE_T  = 5 * (CLK_HZ / 1000);
   localparam int unsigned CW       = 4;

   logic          clk = 1'b0;
   logic          rst;
   logic          rds_on, verbose_sel, irq_on;
   logic [1:0]    pin2_func;
   logic          grp_stb, grp_ok, grp_locked;
   logic [4*CW-1:0] blk_err_cnt;
   logic          ready_flag, sync_flag, gpio2_n;
   logic [7:0]    err_level;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   rds_grp_status #(
      .CLK_HZ(CLK_HZ), .READY_MS(40), .PULSE_MS(5), .ERR_CNT_W(CW)
   ) u_rds_grp_status (
      .clk(clk), .rst(rst), .rds_on(rds_on), .verbose_sel(verbose_sel),
      .irq_on(irq_on), .pin2_func(pin2_func), .grp_stb(grp_stb),
      .grp_ok(grp_ok), .grp_locked(grp_locked), .blk_err_cnt(blk_err_cnt),
      .ready_flag(ready_flag), .sync_flag(sync_flag),
      .err_level(err_level), .gpio2_n(gpio2_n)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [4*CW-1:0] pack(input int a, b, c, d);
      return {CW'(d), CW'(c), CW'(b), CW'(a)};
   endfunction

   task automatic do_reset(input logic verb);
      @(negedge clk);
      rst = 1'b1; rds_on = 1'b1; verbose_sel = verb; irq_on = 1'b0;
      pin2_func = 2'b00; grp_stb = 1'b0; grp_ok = 1'b0; grp_locked = 1'b0;
      blk_err_cnt = '0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic set_mode(input logic verb);
      verbose_sel = verb;
      @(negedge clk);
   endtask

   // leaves the caller at the negedge right after the capturing edge
   task automatic send(input logic ok, input logic lk, input logic [4*CW-1:0] e);
      grp_ok = ok; grp_locked = lk; blk_err_cnt = e; grp_stb = 1'b1;
      @(negedge clk);
      grp_stb = 1'b0;
   endtask

   task automatic t_reset;
      do_reset(1'b1);
      check("R10 reset ready", ready_flag, 0);
      check("R10 reset sync", sync_flag, 0);
      check("R10 reset levels", err_level, 0);
      check("R10 reset pin", gpio2_n, 1);
      // first edge after release still sees standard mode
      send(1'b0, 1'b1, '0);
      check("R10 standard after reset", ready_flag, 0);
      send(1'b0, 1'b1, '0);
      check("R10 verbose one edge later", ready_flag, 1);
   endtask

   task automatic t_standard;
      do_reset(1'b0);
      irq_on = 1'b1; pin2_func = 2'b01;
      send(1'b0, 1'b1, pack(6, 6, 6, 6));
      check("R2 invalid no ready", ready_flag, 0);
      check("R2 invalid no pin", gpio2_n, 1);
      check("R3 standard levels zero", err_level, 0);
      grp_locked = 1'b1;
      @(negedge clk);
      check("R3 standard sync zero", sync_flag, 0);
      send(1'b1, 1'b0, pack(1, 2, 3, 4));
      check("R2 valid sets ready", ready_flag, 1);
      check("R3 standard levels after valid", err_level, 0);
   endtask

   task automatic t_verbose;
      do_reset(1'b1);
      @(negedge clk);
      grp_locked = 1'b1;
      @(negedge clk);
      check("R4 sync rises", sync_flag, 1);
      grp_locked = 1'b0;
      @(negedge clk);
      check("R4 sync falls", sync_flag, 0);
      send(1'b1, 1'b0, '0);
      check("R5 unlocked no ready", ready_flag, 0);
      send(1'b0, 1'b1, '0);
      check("R5 locked invalid sets ready", ready_flag, 1);
   endtask

   task automatic t_hold;
      do_reset(1'b0);
      send(1'b1, 1'b0, '0);
      repeat (READY_T - 1) @(negedge clk);
      check("R6 last hold cycle", ready_flag, 1);
      @(negedge clk);
      check("R6 released on time", ready_flag, 0);
      send(1'b1, 1'b0, '0);
      repeat (2000) @(negedge clk);
      send(1'b1, 1'b0, '0);
      repeat (2000) @(negedge clk);
      check("R6 retrigger extends", ready_flag, 1);
      repeat (READY_T - 1 - 2000) @(negedge clk);
      check("R6 retrigger last cycle", ready_flag, 1);
      @(negedge clk);
      check("R6 retrigger released", ready_flag, 0);
   endtask

   task automatic t_pin;
      do_reset(1'b0);
      irq_on = 1'b1; pin2_func = 2'b01;
      send(1'b1, 1'b0, '0);
      check("R7 pin low", gpio2_n, 0);
      repeat (PULSE_T - 1) @(negedge clk);
      check("R7 pin last low cycle", gpio2_n, 0);
      @(negedge clk);
      check("R7 pin released", gpio2_n, 1);
      check("R7 ready outlasts pin", ready_flag, 1);
      repeat (100) @(negedge clk);
      send(1'b1, 1'b0, '0);
      repeat (PULSE_T - 1) @(negedge clk);
      check("R7 retrigger still low", gpio2_n, 0);
   endtask

   task automatic t_gate;
      for (int k = 0; k < 4; k++) begin
         do_reset(1'b0);
         irq_on = (k == 3) ? 1'b0 : 1'b1;
         pin2_func = (k == 3) ? 2'b01 : ((k == 0) ? 2'b00 : ((k == 1) ? 2'b10 : 2'b11));
         send(1'b1, 1'b0, '0);
         check("R8 pin gated high", gpio2_n, 1);
         check("R8 ready still set", ready_flag, 1);
      end
      do_reset(1'b0);
      irq_on = 1'b1; pin2_func = 2'b01;
      send(1'b1, 1'b0, '0);
      irq_on = 1'b0;
      #1;
      check("R8 enable cleared mid pulse", gpio2_n, 1);
   endtask

   task automatic t_levels;
      do_reset(1'b1);
      @(negedge clk);
      send(1'b0, 1'b0, pack(0, 2, 5, 6));
      check("R9 levels 0/2/5/6", err_level, 8'hE4);
      send(1'b0, 1'b0, pack(1, 3, 15, 0));
      check("R9 levels 1/3/15/0", err_level, 8'h39);
      blk_err_cnt = pack(6, 6, 6, 6);
      repeat (3) @(negedge clk);
      check("R9 held without strobe", err_level, 8'h39);
      send(1'b0, 1'b0, pack(6, 0, 2, 3));
      check("R9 levels 6/0/2/3", err_level, 8'h93);
   endtask

   task automatic t_disable;
      do_reset(1'b1);
      irq_on = 1'b1; pin2_func = 2'b01;
      @(negedge clk);
      send(1'b0, 1'b1, pack(6, 6, 6, 6));
      check("R1 setup ready", ready_flag, 1);
      rds_on = 1'b0;
      @(negedge clk);
      check("R1 ready cleared", ready_flag, 0);
      check("R1 sync cleared", sync_flag, 0);
      check("R1 levels cleared", err_level, 0);
      check("R1 pin high", gpio2_n, 1);
      send(1'b1, 1'b1, pack(6, 6, 6, 6));
      check("R1 strobe ignored", ready_flag, 0);
      check("R1 strobe no pin", gpio2_n, 1);
   endtask

   initial begin
      rst = 1'b1;
      t_reset;
      t_standard;
      t_verbose;
      t_hold;
      t_pin;
      t_gate;
      t_levels;
      t_disable;
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150_000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule